// File: doc/BRIEF.md
# Byte Serial Port Controller with Sticky Status

This block is a single-byte, full-duplex SPI port that a CPU reaches through a small register bus. There are three registers: control, status and data. When the port is master, a CPU write to the data register loads the shift register and starts an eight-bit exchange. The port drives its own serial clock, which it divides down from the system clock. When the port is slave, the same write only preloads the byte to send, and an external master clocks the exchange.

Each received byte lands in a read buffer, and a CPU read of the data register returns that buffer. Four sticky flags in the status register report: a finished transfer, a write made during a transfer, a byte lost because the buffer was still unread, and a slave-select fault while the port is master. Software clears any flag by writing zero to its bit. An interrupt line follows the completion flag when the interrupt enable is set.

Top module: `spi_port`

## Requirements
- R1: Register map by `addr`: 0 is control (bit 7 interrupt enable, bit 6 master, bits DIV_W-1:0 divider value D), 1 is status, 2 is data, and 3 reads as zero. In master mode, a data write that is accepted starts a transfer. `sck_out` idles low, each of its high and low phases lasts D+1 clocks, `mosi_out` sends MSB first, and `miso_in` is sampled on each rising edge of `sck_out`.
- R2: Eight bits after a transfer starts, status bit 7 (completion) sets. The received byte is copied into the read buffer unless an overrun blocks it, and a data-register read returns the read buffer.
- R3: `irq` is high exactly while status bit 7 and control bit 7 are both set.
- R4: While status bit 7 is set, a data-register write is ignored. It starts no transfer, sets no flag and leaves the read data unchanged.
- R5: A data write while a transfer is active, and with bit 7 clear, sets status bit 6 (collision). It does not change the byte being shifted out.
- R6: A byte that completes while the previous byte is unread, or while status bit 5 is already set, sets status bit 5 (overrun). While bit 5 is set, the read buffer keeps its old byte. Reading the data register marks the buffer as read.
- R7: If `ss_n_in` is low while the port is master, status bit 4 (mode fault) sets, control bit 6 clears and any master transfer is abandoned.
- R8: In slave mode, a data write only preloads the transmit byte and leaves `sck_out` idle. While `ss_n_in` is low, the port shifts on `sck_in`: it samples `mosi_in` on the rising edge and shows the next bit on `miso_out` after the falling edge, MSB first.
- R9: A status write of 0 to bit 7, 6, 5 or 4 clears that flag, and a write of 1 leaves it unchanged. Bit 3 is read/write, and bits 2 to 0 read as zero.
- R10: `ss_n_out` is low while a master transfer runs with status bit 3 set, and high otherwise.
- R11: After reset, control and status read 0, `irq` is 0, `sck_out` is 0 and `ss_n_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| addr | input | 2 | Register select |
| wr | input | 1 | Register write strobe |
| rd | input | 1 | Register read strobe (a data read marks the buffer as read) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | Interrupt request |
| sck_out | output | 1 | Serial clock driven in master mode |
| mosi_out | output | 1 | Serial data out in master mode |
| miso_in | input | 1 | Serial data in for master mode |
| ss_n_out | output | 1 | Slave select driven to the remote device |
| sck_in | input | 1 | Serial clock from a remote master |
| mosi_in | input | 1 | Serial data in for slave mode |
| miso_out | output | 1 | Serial data out in slave mode |
| ss_n_in | input | 1 | Slave-select sense, active low |

## Verification
The assertions assume that the external serial clock and slave select in slave mode change slowly compared with the two-stage input synchronizers. The bench holds every phase of `sck_in` for six system clocks, and keeps `mosi_in` stable around each rising edge. They also assume that `ss_n_in` stays high during master traffic, unless a fault is the goal. The bench raises it only in the mode-fault scenario, and only while the port is idle. Register strobes last exactly one clock, so a read has its side effect only once.

// File: rtl/spi_port.sv
module spi_port #(
  parameter int DIV_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr,
  input  logic       rd,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic       sck_out,
  output logic       mosi_out,
  input  logic       miso_in,
  output logic       ss_n_out,
  input  logic       sck_in,
  input  logic       mosi_in,
  output logic       miso_out,
  input  logic       ss_n_in
);
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;

  logic [7:0]       shreg, rbuf, ctrl_rd, stat_rd;
  logic [2:0]       bitcnt;
  logic [DIV_W-1:0] div, cnt;
  logic ien, master, m_busy, sck_q, rxbit, rbuf_full;
  logic done, wcol, ovf, modf, ssctl;
  logic [1:0] sck_sy, ss_sy, mosi_sy;
  logic sck_prev;

  wire ss_s   = ss_sy[1];
  wire sck_s  = sck_sy[1];
  wire mosi_s = mosi_sy[1];

  wire wr_ctrl = wr & (addr == A_CTRL);
  wire wr_stat = wr & (addr == A_STAT);
  wire wr_data = wr & (addr == A_DATA);
  wire rd_data = rd & (addr == A_DATA);

  wire s_sel    = ~master & ~ss_s;
  wire busy_any = m_busy | s_sel;
  wire tick     = m_busy & (cnt == div);
  wire m_rise   = tick & ~sck_q;
  wire m_fall   = tick & sck_q;
  wire s_rise   = s_sel & sck_s & ~sck_prev;
  wire s_fall   = s_sel & ~sck_s & sck_prev;
  wire do_shift = m_fall | s_fall;
  wire complete = do_shift & (bitcnt == 3'd7);
  wire [7:0] rx_byte = {shreg[6:0], rxbit};
  wire fault    = master & ~ss_s;
  wire accept   = wr_data & ~done;
  wire load     = accept & ~busy_any;
  wire collide  = accept & busy_any;

  assign irq      = done & ien;
  assign sck_out  = sck_q;
  assign mosi_out = shreg[7];
  assign miso_out = shreg[7];
  assign ss_n_out = ~(master & ssctl & m_busy);

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[7] = ien;
    ctrl_rd[6] = master;
    ctrl_rd[DIV_W-1:0] = div;
    stat_rd = {done, wcol, ovf, modf, ssctl, 3'b000};
    case (addr)
      A_CTRL:  rdata = ctrl_rd;
      A_STAT:  rdata = stat_rd;
      A_DATA:  rdata = rbuf;
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= '0; ss_sy <= 2'b11; mosi_sy <= '0; sck_prev <= 1'b0;
    end else begin
      sck_sy <= {sck_sy[0], sck_in};
      ss_sy <= {ss_sy[0], ss_n_in};
      mosi_sy <= {mosi_sy[0], mosi_in};
      sck_prev <= sck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0; sck_q <= 1'b0; cnt <= '0;
      rxbit <= 1'b0; shreg <= '0; bitcnt <= '0;
    end else begin
      if (fault) begin
        m_busy <= 1'b0; sck_q <= 1'b0;
      end else if (load && master) begin
        m_busy <= 1'b1; sck_q <= 1'b0; cnt <= '0;
      end else if (m_busy) begin
        if (tick) begin
          cnt <= '0;
          sck_q <= ~sck_q;
          if (complete) m_busy <= 1'b0;
        end else cnt <= cnt + 1'b1;
      end
      if (m_rise) rxbit <= miso_in;
      else if (s_rise) rxbit <= mosi_s;
      if (load) shreg <= wdata;
      else if (do_shift) shreg <= rx_byte;
      if (load || (!master && ss_s)) bitcnt <= '0;
      else if (do_shift) bitcnt <= bitcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0; wcol <= 1'b0; ovf <= 1'b0; modf <= 1'b0; ssctl <= 1'b0;
      rbuf <= '0; rbuf_full <= 1'b0; ien <= 1'b0; master <= 1'b0; div <= '0;
    end else begin
      done <= complete | (done & ~(wr_stat & ~wdata[7]));
      wcol <= collide  | (wcol & ~(wr_stat & ~wdata[6]));
      ovf  <= (complete & (rbuf_full | ovf)) | (ovf & ~(wr_stat & ~wdata[5]));
      modf <= fault    | (modf & ~(wr_stat & ~wdata[4]));
      if (wr_stat) ssctl <= wdata[3];
      if (complete && !rbuf_full && !ovf) begin
        rbuf <= rx_byte; rbuf_full <= 1'b1;
      end else if (rd_data) rbuf_full <= 1'b0;
      if (wr_ctrl) begin
        ien <= wdata[7];
        div <= wdata[DIV_W-1:0];
      end
      if (fault) master <= 1'b0;
      else if (wr_ctrl) master <= wdata[6];
    end
  end

  assert_done_after_last_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    complete |=> done);
  assert_blocked_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && done && !m_busy) |=> !m_busy);
  assert_collision_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !done && m_busy) |=> (wcol && $stable(bitcnt) || $past(do_shift)));
  assert_frozen_buffer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> $stable(rbuf));
  assert_fault_demotes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !ss_s) |=> (modf && !master && !m_busy));
  assert_no_sck_as_slave_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && !m_busy) |=> !sck_out);
endmodule

// File: tb/test_spi_port.sv
module test_spi_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic irq, sck_out, mosi_out, ss_n_out, miso_out;
  logic sck_in = 1'b0, mosi_in = 1'b0, ss_n_in = 1'b1;
  logic [7:0] sbyte = '0, mcap = '0;
  logic miso_in;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_port i_spi_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .rd(rd), .wdata(wdata),
    .rdata(rdata), .irq(irq), .sck_out(sck_out), .mosi_out(mosi_out),
    .miso_in(miso_in), .ss_n_out(ss_n_out), .sck_in(sck_in), .mosi_in(mosi_in),
    .miso_out(miso_out), .ss_n_in(ss_n_in));

  assign miso_in = sbyte[7];
  always @(posedge sck_out) mcap <= {mcap[6:0], mosi_out};
  always @(negedge sck_out) sbyte <= {sbyte[6:0], 1'b0};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd = 1'b1; #1 v = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wait_done();
    logic [7:0] v;
    for (int i = 0; i < 3000; i++) begin
      rreg(2'd1, v);
      if (v[7]) return;
    end
    check(0, "R2 done timeout", 0, 1);
  endtask

  task automatic mxfer(input logic [7:0] tx, input logic [7:0] sb);
    sbyte = sb; mcap = '0;
    wreg(2'd2, tx);
    wait_done();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rreg(2'd0, v); check(v == 8'h00, "R11 control", v, 0);
    rreg(2'd1, v); check(v == 8'h00, "R11 status", v, 0);
    check(irq == 0 && sck_out == 0 && ss_n_out == 1, "R11 pins", {irq, sck_out, ss_n_out}, 3'b001);
  endtask

  task automatic t_master();
    logic [7:0] v; int n;
    wreg(2'd0, 8'h42);
    sbyte = 8'h3C; mcap = '0;
    wreg(2'd2, 8'hA5);
    @(posedge sck_out); n = 0;
    while (sck_out) begin @(posedge clk); #1 n++; end
    check(n == 3, "R1 sck high phase", n, 3);
    wait_done();
    check(mcap == 8'hA5, "R1 mosi byte", mcap, 8'hA5);
    check(irq == 0, "R3 irq masked", irq, 0);
    rreg(2'd1, v); check(v == 8'h80, "R2 status done", v, 8'h80);
    rreg(2'd2, v); check(v == 8'h3C, "R2 read buffer", v, 8'h3C);
    wreg(2'd0, 8'hC2);
    #1 check(irq == 1, "R3 irq enabled", irq, 1);
    wreg(2'd1, 8'hF8);
    rreg(2'd1, v); check(v == 8'h88, "R9 write one keeps", v, 8'h88);
    wreg(2'd1, 8'h00);
    #1 check(irq == 0, "R3 irq after clear", irq, 0);
  endtask

  task automatic t_blocked();
    logic [7:0] v; int rises = 0;
    wreg(2'd0, 8'h40);
    mxfer(8'h12, 8'h6E);
    wreg(2'd2, 8'h11);
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (sck_out) rises++; end
    check(rises == 0, "R4 no transfer", rises, 0);
    rreg(2'd1, v); check(v == 8'h80, "R4 no flag", v, 8'h80);
    rreg(2'd2, v); check(v == 8'h6E, "R4 data kept", v, 8'h6E);
    wreg(2'd1, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    sbyte = 8'h01; mcap = '0;
    wreg(2'd2, 8'hC3);
    wreg(2'd2, 8'h5A);
    wait_done();
    check(mcap == 8'hC3, "R5 shift unaltered", mcap, 8'hC3);
    rreg(2'd1, v); check(v == 8'hC0, "R5 collision flag", v, 8'hC0);
    rreg(2'd2, v);
    wreg(2'd1, 8'h00);
    rreg(2'd1, v); check(v == 8'h00, "R9 zero clears", v, 0);
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    wreg(2'd0, 8'h40);
    mxfer(8'h01, 8'h3C); wreg(2'd1, 8'h00);
    mxfer(8'h02, 8'h77);
    rreg(2'd1, v); check(v == 8'hA0, "R6 overrun set", v, 8'hA0);
    rreg(2'd2, v); check(v == 8'h3C, "R6 old byte kept", v, 8'h3C);
    wreg(2'd1, 8'h20);
    mxfer(8'h03, 8'h55);
    rreg(2'd2, v); check(v == 8'h3C, "R6 frozen while flag", v, 8'h3C);
    wreg(2'd1, 8'h00);
    mxfer(8'h04, 8'h99);
    rreg(2'd1, v); check(v == 8'h80, "R6 overrun cleared", v, 8'h80);
    rreg(2'd2, v); check(v == 8'h99, "R6 buffer resumes", v, 8'h99);
    wreg(2'd1, 8'h00);
  endtask

  task automatic t_ssout();
    logic [7:0] v;
    wreg(2'd1, 8'h08);
    sbyte = 8'h00;
    wreg(2'd2, 8'h0F);
    @(posedge sck_out); #1;
    check(ss_n_out == 0, "R10 select low", ss_n_out, 0);
    wait_done();
    check(ss_n_out == 1, "R10 select released", ss_n_out, 1);
    rreg(2'd1, v); check(v == 8'h88, "R9 bit3 readback", v, 8'h88);
    rreg(2'd2, v);
    wreg(2'd1, 8'h0F);
    rreg(2'd1, v); check(v == 8'h08, "R9 reserved zero", v, 8'h08);
    wreg(2'd1, 8'h00);
  endtask

  task automatic t_fault();
    logic [7:0] v;
    wreg(2'd0, 8'h40);
    @(negedge clk); ss_n_in = 1'b0;
    repeat (5) @(negedge clk);
    rreg(2'd1, v); check(v == 8'h10, "R7 fault flag", v, 8'h10);
    rreg(2'd0, v); check(v[6] == 0, "R7 demoted to slave", v, 0);
    ss_n_in = 1'b1;
    repeat (4) @(negedge clk);
    wreg(2'd1, 8'h00);
  endtask

  task automatic t_slave();
    logic [7:0] v, cap = '0, din = 8'h5A; int rises = 0;
    wreg(2'd0, 8'h00);
    wreg(2'd2, 8'h96);
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (sck_out) rises++; end
    check(rises == 0, "R8 no clock as slave", rises, 0);
    ss_n_in = 1'b0;
    repeat (4) @(negedge clk);
    for (int b = 7; b >= 0; b--) begin
      mosi_in = din[b];
      repeat (6) @(negedge clk);
      sck_in = 1'b1; cap = {cap[6:0], miso_out};
      repeat (6) @(negedge clk);
      sck_in = 1'b0;
    end
    repeat (6) @(negedge clk);
    ss_n_in = 1'b1;
    repeat (4) @(negedge clk);
    check(cap == 8'h96, "R8 preloaded byte sent", cap, 8'h96);
    rreg(2'd1, v); check(v == 8'h80, "R8 slave done", v, 8'h80);
    rreg(2'd2, v); check(v == 8'h5A, "R8 slave received", v, 8'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_master();
    t_blocked();
    t_collide();
    t_overrun();
    t_ssout();
    t_fault();
    t_slave();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule